// File: doc/BRIEF.md
# USB Endpoint and Bus Event Interrupt Controller

This block collects interrupt events for a USB controller and presents them to a CPU through a small register interface. It has three status banks: one for the transmit side (endpoint 0 plus transmit endpoints 1 to 15), one for the receive side (receive endpoints 1 to 15), and one for eight bus-level events. Each status bank has a matching enable register. A one-cycle event pulse sets its status bit, whatever the enable holds. Reading a status register returns its contents and clears every bit that was set, all in the same access.

A single active-low interrupt line is driven low while any status bit is set together with its enable bit. The line is registered, so it follows the status by one clock. Two parameters say which transmit and receive endpoints exist. Status and enable bits of endpoints that do not exist are held at zero and cannot be written. The enable reset values are masked by the same parameters.

Top module: `usb_irq_ctrl`

## Requirements
- R1: A pulse on `ev_tx[i]` for an implemented transmit endpoint sets transmit status bit i at the next clock edge, and the bit stays set until a clearing read. Bit 0 is endpoint 0. A status bit is set even when its enable bit is 0.
- R2: Receive status bit 0 and receive enable bit 0 always read 0. Receive endpoints occupy bits 1 to 15.
- R3: A read (`rd_en` high) of a status register returns its value in the same cycle on `rdata` and clears all of that register's bits at the clock edge. The other registers are not affected.
- R4: An event that arrives in the same cycle as a clearing read of its register is set after that edge, so it is not lost.
- R5: Status and enable bits of endpoints whose bit is 0 in `TX_EP_MASK` / `RX_EP_MASK` always read 0, and writes to those enable bits have no effect.
- R6: After reset the transmit enable reads 0xFFFF masked by the implemented transmit endpoints. The receive enable reads 0xFFFE masked by the implemented receive endpoints. The bus enable reads 0x06. All status registers read 0.
- R7: Bus status bits, from 7 down to 0, are: VBus error, session request, disconnect, connect, start of frame, reset (peripheral role) or babble (host role), resume, suspend. `ev_bus[k]` sets bit k.
- R8: `irq_n` is low in the cycle after a cycle in which any status bit and its enable bit are both 1. Otherwise it is high. It is high after reset.
- R9: Address map on `addr`: 0 transmit status, 1 receive status, 2 bus status (bits 15:8 read 0), 4 transmit enable, 5 receive enable, 6 bus enable. Addresses 3 and 7 read 0. Writes to addresses 0 to 3 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe; clears the status register that is read |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the register at `addr` (combinational) |
| ev_tx | input | 16 | Transmit-side event pulses, bit 0 is endpoint 0 |
| ev_rx | input | 16 | Receive-side event pulses, bit 0 is ignored |
| ev_bus | input | 8 | Bus event pulses |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with `TX_EP_MASK` = 0x807F and `RX_EP_MASK` = 0x0F0F. The transmit mask leaves a gap between implemented endpoints and keeps the top endpoint. The receive mask sets bit 0 on purpose, so the bench can show that the receive endpoint-0 slot stays zero even when a mask asks for it. With these values, unimplemented bits sit between implemented ones, at both ends of a register, and inside event and write patterns, so every masking rule can be seen at the ports.

// File: rtl/usb_irq_pkg.sv
// Package: register select codes shared by the controller and its banks.
// Assumes a 3-bit register select on the CPU side.
package usb_irq_pkg;
    localparam logic [2:0] SEL_TX_STAT = 3'd0;
    localparam logic [2:0] SEL_RX_STAT = 3'd1;
    localparam logic [2:0] SEL_BUS_STAT = 3'd2;
    localparam logic [2:0] SEL_TX_EN = 3'd4;
    localparam logic [2:0] SEL_RX_EN = 3'd5;
    localparam logic [2:0] SEL_BUS_EN = 3'd6;
    localparam int DATA_W = 16;
    localparam int BUS_W = 8;
endpackage

// File: rtl/usb_irq_bank.sv
// Module: one status/enable register pair with clear-on-read.
// Event pulses set status bits. A clearing read zeroes the register, but
// events in the same cycle still land. Bits outside IMPL are held at zero.
// Assumes rd_clr and en_we are single-cycle strobes from the decoder.
module usb_irq_bank #(
    parameter int W = 16,
    parameter logic [W-1:0] IMPL = '1,
    parameter logic [W-1:0] EN_RST = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev,
    input  logic         rd_clr,
    input  logic         en_we,
    input  logic [W-1:0] en_wdata,
    output logic [W-1:0] stat,
    output logic [W-1:0] en,
    output logic         pend
);
    localparam logic [W-1:0] EN_INIT = EN_RST & IMPL;

    // Status update: clear on read, then merge in new events.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat <= '0;
        else
            stat <= ((rd_clr ? '0 : stat) | ev) & IMPL;
    end

    // Enable register: masked writes only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en <= EN_INIT;
        else if (en_we)
            en <= en_wdata & IMPL;
    end

    // Pending: some enabled bit is set.
    always_comb pend = |(stat & en);

    // R5
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat | en) & ~IMPL) == '0);

    // R3
    clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> stat == ($past(ev) & IMPL));

    // R1
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ev & IMPL)) |=> ((stat & $past(ev & IMPL)) == $past(ev & IMPL)));

    // R4
    no_event_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && |(ev & IMPL)) |=> (stat != '0));
endmodule

// File: rtl/usb_irq_merge.sv
// Module: merges the pending flags of the banks into a registered
// active-low interrupt line. Assumes the pending inputs come from registers.
module usb_irq_merge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend,
    output logic         irq_n
);
    // Registered OR of all pending flags, inverted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_n <= 1'b1;
        else
            irq_n <= ~(|pend);
    end

    // R8
    irq_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |=> !irq_n);

    // R8
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|pend) |=> irq_n);
endmodule

// File: rtl/usb_irq_ctrl.sv
// Module: USB interrupt controller top. Decodes the CPU register access,
// drives the three banks and muxes the read data.
// Assumes rd_en and wr_en are not both used for one access; a read clears
// the status register it selects. The receive bit 0 is always unimplemented.
module usb_irq_ctrl
    import usb_irq_pkg::*;
#(
    parameter logic [15:0] TX_EP_MASK = 16'h00FF,
    parameter logic [15:0] RX_EP_MASK = 16'h00FE
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    input  logic [15:0] ev_tx,
    input  logic [15:0] ev_rx,
    input  logic [7:0]  ev_bus,
    output logic        irq_n
);
    localparam logic [DATA_W-1:0] TX_IMPL = TX_EP_MASK;
    localparam logic [DATA_W-1:0] RX_IMPL = RX_EP_MASK & 16'hFFFE;

    logic [DATA_W-1:0] tx_stat, tx_en, rx_stat, rx_en;
    logic [BUS_W-1:0]  bus_stat, bus_en;
    logic [2:0]        pend;
    logic              clr_tx, clr_rx, clr_bus, we_tx, we_rx, we_bus;

    // Access decode: read strobes clear status, write strobes load enables.
    always_comb begin
        clr_tx  = rd_en && (addr == SEL_TX_STAT);
        clr_rx  = rd_en && (addr == SEL_RX_STAT);
        clr_bus = rd_en && (addr == SEL_BUS_STAT);
        we_tx   = wr_en && (addr == SEL_TX_EN);
        we_rx   = wr_en && (addr == SEL_RX_EN);
        we_bus  = wr_en && (addr == SEL_BUS_EN);
    end

    usb_irq_bank #(.W(DATA_W), .IMPL(TX_IMPL), .EN_RST(16'hFFFF)) u_tx (
        .clk(clk), .rst_n(rst_n), .ev(ev_tx), .rd_clr(clr_tx),
        .en_we(we_tx), .en_wdata(wdata), .stat(tx_stat), .en(tx_en),
        .pend(pend[0]));

    usb_irq_bank #(.W(DATA_W), .IMPL(RX_IMPL), .EN_RST(16'hFFFE)) u_rx (
        .clk(clk), .rst_n(rst_n), .ev(ev_rx), .rd_clr(clr_rx),
        .en_we(we_rx), .en_wdata(wdata), .stat(rx_stat), .en(rx_en),
        .pend(pend[1]));

    usb_irq_bank #(.W(BUS_W), .IMPL(8'hFF), .EN_RST(8'h06)) u_bus (
        .clk(clk), .rst_n(rst_n), .ev(ev_bus), .rd_clr(clr_bus),
        .en_we(we_bus), .en_wdata(wdata[BUS_W-1:0]), .stat(bus_stat),
        .en(bus_en), .pend(pend[2]));

    usb_irq_merge #(.N(3)) u_merge (
        .clk(clk), .rst_n(rst_n), .pend(pend), .irq_n(irq_n));

    // Read data mux; unmapped selects read zero.
    always_comb begin
        case (addr)
            SEL_TX_STAT:  rdata = tx_stat;
            SEL_RX_STAT:  rdata = rx_stat;
            SEL_BUS_STAT: rdata = {{(DATA_W-BUS_W){1'b0}}, bus_stat};
            SEL_TX_EN:    rdata = tx_en;
            SEL_RX_EN:    rdata = rx_en;
            SEL_BUS_EN:   rdata = {{(DATA_W-BUS_W){1'b0}}, bus_en};
            default:      rdata = '0;
        endcase
    end

    // R2
    rx_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_stat[0] && !rx_en[0]);

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 3'd3 || addr == 3'd7) |-> rdata == 16'h0000);
endmodule

// File: tb/sim_usb_irq_ctrl.sv
`timescale 1ns/1ps
module sim_usb_irq_ctrl;
    localparam logic [15:0] TXM = 16'h807F;
    localparam logic [15:0] RXM = 16'h0F0F;
    localparam logic [15:0] RXI = RXM & 16'hFFFE;

    logic clk = 1'b0, rst_n = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [15:0] wdata = '0, rdata, ev_tx = '0, ev_rx = '0;
    logic [7:0] ev_bus = '0;
    logic irq_n;
    int n_run = 0, n_fail = 0;

    logic [15:0] m_txs, m_rxs, m_txe, m_rxe;
    logic [7:0] m_buss, m_buse;
    logic m_irq;

    always #5 clk = ~clk;

    usb_irq_ctrl #(.TX_EP_MASK(TXM), .RX_EP_MASK(RXM)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ev_tx(ev_tx), .ev_rx(ev_rx),
        .ev_bus(ev_bus), .irq_n(irq_n));

    function automatic logic [15:0] model_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_txs;
            3'd1: return m_rxs;
            3'd2: return {8'h00, m_buss};
            3'd4: return m_txe;
            3'd5: return m_rxe;
            3'd6: return {8'h00, m_buse};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_txs = '0; m_rxs = '0; m_buss = '0;
        m_txe = 16'hFFFF & TXM; m_rxe = 16'hFFFE & RXI; m_buse = 8'h06;
        m_irq = 1'b1;
    endtask

    // One cycle: drive at negedge, check rdata and irq_n, advance model at posedge.
    task automatic cyc(input string tag, input logic rd, input logic wr,
                       input logic [2:0] a, input logic [15:0] wd,
                       input logic [15:0] et, input logic [15:0] er, input logic [7:0] eb);
        logic pend;
        @(negedge clk);
        rd_en = rd; wr_en = wr; addr = a; wdata = wd;
        ev_tx = et; ev_rx = er; ev_bus = eb;
        #1;
        if (rd) check(tag, rdata, model_rd(a));
        check("R8", {15'd0, irq_n}, {15'd0, m_irq});
        pend = |(m_txs & m_txe) | |(m_rxs & m_rxe) | |(m_buss & m_buse);
        @(posedge clk);
        m_irq = ~pend;
        m_txs  = (((rd && a == 3'd0) ? 16'h0 : m_txs) | et) & TXM;
        m_rxs  = (((rd && a == 3'd1) ? 16'h0 : m_rxs) | er) & RXI;
        m_buss = ((rd && a == 3'd2) ? 8'h0 : m_buss) | eb;
        if (wr && a == 3'd4) m_txe = wd & TXM;
        if (wr && a == 3'd5) m_rxe = wd & RXI;
        if (wr && a == 3'd6) m_buse = wd[7:0];
    endtask

    task automatic rd_reg(input string tag, input logic [2:0] a);
        cyc(tag, 1'b1, 1'b0, a, 16'h0, 16'h0, 16'h0, 8'h0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R10-style reset state and R6 enable reset values
        check("R8", {15'd0, irq_n}, 16'd1);
        rd_reg("R6", 3'd4); rd_reg("R6", 3'd5); rd_reg("R6", 3'd6);
        rd_reg("R6", 3'd0); rd_reg("R6", 3'd1); rd_reg("R6", 3'd2);
        // R5: write all ones, only implemented bits stick
        cyc("R5", 1'b0, 1'b1, 3'd4, 16'hFFFF, 0, 0, 0);
        cyc("R5", 1'b0, 1'b1, 3'd5, 16'hFFFF, 0, 0, 0);
        rd_reg("R5", 3'd4); rd_reg("R5", 3'd5);
        // R2 / R5: events on every bit, unimplemented ones stay 0
        cyc("R1", 1'b0, 1'b0, 3'd3, 0, 16'hFFFF, 16'hFFFF, 8'h00);
        rd_reg("R1", 3'd0); rd_reg("R2", 3'd1);
        rd_reg("R3", 3'd0); rd_reg("R3", 3'd1);
        // R9: writes to status/unmapped addresses ignored, unmapped read 0
        cyc("R9", 1'b0, 1'b0, 3'd3, 0, 16'h0001, 0, 8'h10);
        cyc("R9", 1'b0, 1'b1, 3'd0, 16'h0000, 0, 0, 0);
        cyc("R9", 1'b0, 1'b1, 3'd7, 16'h0000, 0, 0, 0);
        rd_reg("R9", 3'd3); rd_reg("R9", 3'd7);
        rd_reg("R9", 3'd0);
        // R3: reading tx leaves bus untouched
        rd_reg("R3", 3'd2); rd_reg("R3", 3'd2);
        // R4: event in the same cycle as clearing read survives
        cyc("R4", 1'b0, 1'b0, 3'd3, 0, 16'h0003, 0, 0);
        cyc("R4", 1'b1, 1'b0, 3'd0, 0, 16'h0040, 0, 0);
        rd_reg("R4", 3'd0);
        // R7: each bus bit at its position
        for (int k = 0; k < 8; k++) begin
            cyc("R7", 1'b0, 1'b0, 3'd3, 0, 0, 0, 8'(1 << k));
            rd_reg("R7", 3'd2);
        end
        // R8: disabled status does not drive irq, enabled does
        cyc("R8", 1'b0, 1'b1, 3'd6, 16'h0000, 0, 0, 0);
        cyc("R8", 1'b0, 1'b0, 3'd3, 0, 0, 0, 8'h80);
        cyc("R8", 1'b0, 1'b0, 3'd3, 0, 0, 0, 0);
        cyc("R8", 1'b0, 1'b1, 3'd6, 16'h0080, 0, 0, 0);
        cyc("R8", 1'b0, 1'b0, 3'd3, 0, 0, 0, 0);
        cyc("R8", 1'b0, 1'b0, 3'd3, 0, 0, 0, 0);
        rd_reg("R8", 3'd2);
        cyc("R8", 1'b0, 1'b0, 3'd3, 0, 0, 0, 0);
        cyc("R8", 1'b0, 1'b0, 3'd3, 0, 0, 0, 0);
        // Random traffic with a fixed seed
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] a;
            logic rd, wr;
            logic [15:0] et, er;
            logic [7:0] eb;
            a = 3'($urandom_range(0, 7));
            rd = ($urandom_range(0, 3) == 0);
            wr = !rd && ($urandom_range(0, 5) == 0);
            et = ($urandom_range(0, 5) == 0) ? 16'($urandom) : 16'h0;
            er = ($urandom_range(0, 5) == 0) ? 16'($urandom) : 16'h0;
            eb = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h0;
            cyc(rd ? "R3" : "R1", rd, wr, a, 16'($urandom), et, er, eb);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule